// File: doc/BRIEF.md
# TLB Programming Register Interface

This block connects a processor's general-purpose register moves to a software-managed, set-associative translation buffer. It holds a banked file of support registers. The active bank is chosen by a small bank-select register. Two of the four banks, bank 1 and bank 2, each own a separate entry array of 4 sets by 16 indices.

In those two banks, some support registers have side effects:

- Writing the page-high register (index 6) also copies the value into the fault-cause register (index 3).
- Writing the page-low register (index 5) commits a new entry. Its low word is the written value and its high word is the value currently held in the cause register.
- The slot is chosen by the entry-select register (index 4). Bits 5:4 give the set and bits 3:0 give the index.

If the entry being replaced was valid (low word bit 3 set), the block emits a one-cycle flush request. The request carries the old virtual page as an 8 KiB-aligned address. Reads in a TLB bank reload the page-high and page-low mirror registers from the selected entry. A read of either mirror returns that entry's contents.

Banks 0 and 3 behave as plain register storage. Read data is registered and appears one cycle after the read strobe.

Top module: `tlbw_regif`

## Requirements
- R1: After reset, every support register in every bank and every entry in both arrays reads as zero. `flush_req` is 0 and `rd_data` is 0.
- R2: `bsel_wdata` written with `bsel_we` selects the active bank (0..3). Reads and writes of support registers use only the active bank's slots, so banks hold independent values.
- R3: In banks 0 and 3, writes to indices 5 and 6 are plain stores. They never change index 3, never commit an entry and never raise `flush_req`.
- R4: In bank 1 or 2, a write to index 6 stores the value in index 6 and also in index 3 of the same bank.
- R5: In bank 1 or 2, a write to index 5 stores the entry {high = current index 3, low = written value} at set = index-4 bits 5:4 and slot = index-4 bits 3:0 of that bank's array.
- R6: Bank 1 and bank 2 use separate entry arrays and separate support registers. A commit in one is never visible in the other.
- R7: A commit whose replaced entry had low-word bit 3 set drives `flush_req` high for exactly the next cycle. At that time `flush_addr` equals the replaced high word with bits 12:0 cleared. A commit over an invalid entry raises no request.
- R8: In bank 1 or 2, a read of index 5 or 6 returns the low or high word of the entry currently chosen by index 4, reloading the mirrors first.
- R9: `rd_data` updates one cycle after `rd_en` and holds otherwise. A write and a read of the same register in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bsel_we | input | 1 | Bank-select register write strobe |
| bsel_wdata | input | 2 | New active bank number |
| wr_en | input | 1 | Support-register write strobe |
| wr_addr | input | 4 | Support-register index to write |
| wr_data | input | 32 | Write value |
| rd_en | input | 1 | Support-register read strobe |
| rd_addr | input | 4 | Support-register index to read |
| rd_data | output | 32 | Registered read value |
| flush_req | output | 1 | One-cycle request to drop a replaced page |
| flush_addr | output | 32 | Page-aligned address of the replaced entry |

## Verification
The assertions take for granted that `rd_en` stays low while reset is held, so that read data is quiet on the first cycle after reset. They also assume the bank number is changed only through the bank-select strobe. The directed stimulus drives every input on the falling edge and keeps `rd_en` low during reset. It moves between banks only through `bsel_we`, leaving a full cycle between a bank change and the next access. A flush request is then attributable to exactly one earlier write to index 5 made while bank 1 or 2 was active.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  localparam int unsigned TLBW_XLEN      = 32;
  localparam int unsigned TLBW_REG_AW    = 4;
  localparam int unsigned TLBW_BANK_W    = 2;
  // support register roles inside a bank
  localparam int unsigned TLBW_CAUSE_IDX = 3;
  localparam int unsigned TLBW_SEL_IDX   = 4;
  localparam int unsigned TLBW_LO_IDX    = 5;
  localparam int unsigned TLBW_HI_IDX    = 6;

  function automatic logic [TLBW_XLEN-1:0] page_base(input logic [TLBW_XLEN-1:0] hi,
                                                     input int unsigned shift);
    logic [TLBW_XLEN-1:0] m;
    m = (TLBW_XLEN'(1) << shift) - TLBW_XLEN'(1);
    return hi & ~m;
  endfunction
endpackage

// File: rtl/tlbw_regfile.sv
module tlbw_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 4,
  parameter int unsigned BW     = 2,
  parameter int unsigned SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BW-1:0]     bank,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cause_we,
  input  logic              mir_we,
  input  logic [DATA_W-1:0] mir_hi,
  input  logic [DATA_W-1:0] mir_lo,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_val,
  output logic [SEL_W-1:0]  sel_val,
  output logic [DATA_W-1:0] cause_val
);
  import tlbw_pkg::*;

  localparam int unsigned NBANK = 1 << BW;
  localparam int unsigned NREG  = 1 << AW;

  logic [DATA_W-1:0] regs [NBANK][NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANK; b++)
        for (int r = 0; r < NREG; r++)
          regs[b][r] <= '0;
    end else begin
      if (mir_we) begin
        regs[bank][AW'(TLBW_HI_IDX)] <= mir_hi;
        regs[bank][AW'(TLBW_LO_IDX)] <= mir_lo;
      end
      if (cause_we)
        regs[bank][AW'(TLBW_CAUSE_IDX)] <= wr_data;
      // the direct write is last so it wins over mirror reloads
      if (wr_en)
        regs[bank][wr_addr] <= wr_data;
    end
  end

  logic [DATA_W-1:0] sel_full;
  assign rd_val    = regs[bank][rd_addr];
  assign sel_full  = regs[bank][AW'(TLBW_SEL_IDX)];
  assign sel_val   = sel_full[SEL_W-1:0];
  assign cause_val = regs[bank][AW'(TLBW_CAUSE_IDX)];
endmodule

// File: rtl/tlbw_entry_ram.sv
module tlbw_entry_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_hi,
  input  logic [DATA_W-1:0] wr_lo,
  output logic [DATA_W-1:0] rd_hi,
  output logic [DATA_W-1:0] rd_lo
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [2*DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]    written;

  // storage without reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (we)
      mem[addr] <= {wr_hi, wr_lo};
  end

  always_ff @(posedge clk) begin
    if (rst)
      written <= '0;
    else if (we)
      written[addr] <= 1'b1;
  end

  logic [2*DATA_W-1:0] word;
  assign word  = written[addr] ? mem[addr] : '0;
  assign rd_hi = word[2*DATA_W-1:DATA_W];
  assign rd_lo = word[DATA_W-1:0];
endmodule

// File: rtl/tlbw_regif.sv
module tlbw_regif #(
  parameter int unsigned DATA_W         = tlbw_pkg::TLBW_XLEN,
  parameter int unsigned REG_AW         = tlbw_pkg::TLBW_REG_AW,
  parameter int unsigned BANK_W         = tlbw_pkg::TLBW_BANK_W,
  parameter int unsigned SET_W          = 2,
  parameter int unsigned IDX_W          = 4,
  parameter int unsigned PAGE_SHIFT     = 13,
  parameter int unsigned VALID_BIT      = 3,
  parameter int unsigned TLB_BANK_FIRST = 1,
  parameter int unsigned TLB_BANKS      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bsel_we,
  input  logic [BANK_W-1:0] bsel_wdata,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              flush_req,
  output logic [DATA_W-1:0] flush_addr
);
  import tlbw_pkg::*;

  localparam int unsigned ENT_AW = SET_W + IDX_W;
  localparam int unsigned TSW    = (TLB_BANKS > 1) ? $clog2(TLB_BANKS) : 1;
  localparam logic [DATA_W-1:0] PAGE_MASK = (DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1);

  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst)          bank_q <= '0;
    else if (bsel_we) bank_q <= bsel_wdata;
  end

  // which entry array (if any) belongs to the active bank
  logic           in_tlb;
  logic [TSW-1:0] tlb_idx;
  always_comb begin
    in_tlb  = 1'b0;
    tlb_idx = '0;
    for (int t = 0; t < TLB_BANKS; t++) begin
      if (bank_q == BANK_W'(TLB_BANK_FIRST + t)) begin
        in_tlb  = 1'b1;
        tlb_idx = TSW'(t);
      end
    end
  end

  logic wr_lo_hit, wr_hi_hit, commit, cause_we, mir_we;
  assign wr_lo_hit = wr_en && (wr_addr == REG_AW'(TLBW_LO_IDX));
  assign wr_hi_hit = wr_en && (wr_addr == REG_AW'(TLBW_HI_IDX));
  assign commit    = in_tlb && wr_lo_hit;
  assign cause_we  = in_tlb && wr_hi_hit;
  assign mir_we    = in_tlb && rd_en;

  logic [DATA_W-1:0] rf_rd_val, cause_val, cur_hi, cur_lo;
  logic [ENT_AW-1:0] sel_val;

  tlbw_regfile #(
    .DATA_W(DATA_W), .AW(REG_AW), .BW(BANK_W), .SEL_W(ENT_AW)
  ) u_rf (
    .clk      (clk),
    .rst      (rst),
    .bank     (bank_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cause_we (cause_we),
    .mir_we   (mir_we),
    .mir_hi   (cur_hi),
    .mir_lo   (cur_lo),
    .rd_addr  (rd_addr),
    .rd_val   (rf_rd_val),
    .sel_val  (sel_val),
    .cause_val(cause_val)
  );

  logic [DATA_W-1:0] ram_hi [TLB_BANKS];
  logic [DATA_W-1:0] ram_lo [TLB_BANKS];

  for (genvar t = 0; t < TLB_BANKS; t++) begin : g_arr
    tlbw_entry_ram #(.DATA_W(DATA_W), .ADDR_W(ENT_AW)) u_ram (
      .clk  (clk),
      .rst  (rst),
      .we   (commit && (tlb_idx == TSW'(t))),
      .addr (sel_val),
      .wr_hi(cause_val),
      .wr_lo(wr_data),
      .rd_hi(ram_hi[t]),
      .rd_lo(ram_lo[t])
    );
  end

  // old entry contents, read before the commit lands
  assign cur_hi = ram_hi[tlb_idx];
  assign cur_lo = ram_lo[tlb_idx];

  logic old_valid;
  assign old_valid = cur_lo[VALID_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_req  <= 1'b0;
      flush_addr <= '0;
    end else begin
      flush_req <= commit && old_valid;
      if (commit && old_valid)
        flush_addr <= cur_hi & ~PAGE_MASK;
    end
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = rf_rd_val;
    if (in_tlb && rd_addr == REG_AW'(TLBW_HI_IDX)) rd_next = cur_hi;
    if (in_tlb && rd_addr == REG_AW'(TLBW_LO_IDX)) rd_next = cur_lo;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/tlbw_regif_chk.sv
module tlbw_regif_chk #(
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned REG_AW         = 4,
  parameter int unsigned BANK_W         = 2,
  parameter int unsigned PAGE_SHIFT     = 13,
  parameter int unsigned TLB_BANK_FIRST = 1,
  parameter int unsigned TLB_BANKS      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              flush_req,
  input logic [DATA_W-1:0] flush_addr,
  input logic [BANK_W-1:0] bank_q
);
  localparam logic [DATA_W-1:0] PMASK = (DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1);

  logic bank_is_tlb;
  assign bank_is_tlb = (int'(bank_q) >= int'(TLB_BANK_FIRST)) &&
                       (int'(bank_q) <  int'(TLB_BANK_FIRST + TLB_BANKS));

  // R7
  flush_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(wr_en && wr_addr == REG_AW'(tlbw_pkg::TLBW_LO_IDX)));

  // R7
  flush_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> ((flush_addr & PMASK) == '0));

  // R3
  flush_bank_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(bank_is_tlb));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flush_req && rd_data == '0));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));
endmodule

bind tlbw_regif tlbw_regif_chk #(
  .DATA_W(DATA_W), .REG_AW(REG_AW), .BANK_W(BANK_W), .PAGE_SHIFT(PAGE_SHIFT),
  .TLB_BANK_FIRST(TLB_BANK_FIRST), .TLB_BANKS(TLB_BANKS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
  .rd_data(rd_data), .flush_req(flush_req), .flush_addr(flush_addr), .bank_q(bank_q)
);

// File: tb/sim_tlbw_regif.sv
`timescale 1ns/1ps
module sim_tlbw_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bsel_we = 1'b0;
  logic [1:0]  bsel_wdata = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        flush_req;
  logic [31:0] flush_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tlbw_regif u0 (
    .clk(clk), .rst(rst), .bsel_we(bsel_we), .bsel_wdata(bsel_wdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .flush_req(flush_req), .flush_addr(flush_addr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_bank(input logic [1:0] b);
    @(negedge clk); bsel_we = 1'b1; bsel_wdata = b;
    @(negedge clk); bsel_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rd_data after reset", rd_data, 32'h0);
    chk("R1 flush_req after reset", {31'h0, flush_req}, 32'h0);
    rd(4'd7, v);  chk("R1 bank0 reg7", v, 32'h0);
    set_bank(2'd1);
    rd(4'd5, v);  chk("R1 bank1 entry lo", v, 32'h0);
    rd(4'd6, v);  chk("R1 bank1 entry hi", v, 32'h0);
    rd(4'd3, v);  chk("R1 bank1 cause", v, 32'h0);
  endtask

  task automatic t_banks();
    logic [31:0] v;
    set_bank(2'd0); wr(4'd2, 32'hA0A0_0001);
    set_bank(2'd3); wr(4'd2, 32'hB0B0_0003);
    set_bank(2'd0); rd(4'd2, v); chk("R2 bank0 reg2", v, 32'hA0A0_0001);
    set_bank(2'd3); rd(4'd2, v); chk("R2 bank3 reg2", v, 32'hB0B0_0003);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    set_bank(2'd3);
    wr(4'd6, 32'hCAFE_F00D); chk("R3 no flush on bank3 hi", {31'h0, flush_req}, 32'h0);
    wr(4'd5, 32'h0000_0008); chk("R3 no flush on bank3 lo", {31'h0, flush_req}, 32'h0);
    wr(4'd5, 32'h0000_0009); chk("R3 no flush on bank3 lo rewrite", {31'h0, flush_req}, 32'h0);
    rd(4'd3, v); chk("R3 bank3 cause untouched", v, 32'h0);
    rd(4'd6, v); chk("R3 bank3 hi plain", v, 32'hCAFE_F00D);
    rd(4'd5, v); chk("R3 bank3 lo plain", v, 32'h0000_0009);
  endtask

  task automatic t_hi_cause();
    logic [31:0] v;
    set_bank(2'd1);
    wr(4'd6, 32'h1234_BFFF);
    rd(4'd3, v); chk("R4 cause follows hi", v, 32'h1234_BFFF);
  endtask

  task automatic t_commit();
    logic [31:0] v;
    set_bank(2'd1);
    wr(4'd4, 32'h0000_0025);
    wr(4'd5, 32'h0000_0008);
    chk("R7 no flush over invalid", {31'h0, flush_req}, 32'h0);
    rd(4'd6, v); chk("R5 entry hi from cause", v, 32'h1234_BFFF);
    rd(4'd5, v); chk("R5 entry lo", v, 32'h0000_0008);
    wr(4'd4, 32'h0000_0015);
    rd(4'd5, v); chk("R5 other set empty", v, 32'h0);
    wr(4'd4, 32'h0000_0024);
    rd(4'd5, v); chk("R5 other index empty", v, 32'h0);
    wr(4'd4, 32'h0000_0025);
    rd(4'd6, v); chk("R8 read follows select", v, 32'h1234_BFFF);
  endtask

  task automatic t_isolation();
    logic [31:0] v;
    set_bank(2'd2);
    wr(4'd4, 32'h0000_0025);
    rd(4'd5, v); chk("R6 bank2 entry lo empty", v, 32'h0);
    rd(4'd6, v); chk("R6 bank2 entry hi empty", v, 32'h0);
    rd(4'd3, v); chk("R6 bank2 cause separate", v, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    set_bank(2'd1);
    wr(4'd6, 32'h0000_2000);
    wr(4'd5, 32'h0000_0000);
    chk("R7 flush pulse", {31'h0, flush_req}, 32'h1);
    chk("R7 flush address", flush_addr, 32'h1234_A000);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'h0, flush_req}, 32'h0);
    wr(4'd5, 32'h0000_0008);
    chk("R7 no flush over cleared entry", {31'h0, flush_req}, 32'h0);
    rd(4'd6, v); chk("R8 entry hi updated", v, 32'h0000_2000);
    wr(4'd5, 32'h0000_0000);
    chk("R7 second flush pulse", {31'h0, flush_req}, 32'h1);
    chk("R7 second flush address", flush_addr, 32'h0000_2000);
  endtask

  task automatic t_rw_same();
    logic [31:0] v;
    set_bank(2'd0);
    wr(4'd9, 32'h0000_0111);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd9; wr_data = 32'h0000_0222;
    rd_en = 1'b1; rd_addr = 4'd9;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 same-cycle read old", rd_data, 32'h0000_0111);
    repeat (3) @(negedge clk);
    chk("R9 read data held", rd_data, 32'h0000_0111);
    rd(4'd9, v); chk("R9 new value later", v, 32'h0000_0222);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_banks();
    t_plain();
    t_hi_cause();
    t_commit();
    t_isolation();
    t_flush();
    t_rw_same();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule